// File: doc/BRIEF.md
# Mesh Barrier Aggregation Network

This block is a one-bit global barrier for a K by K mesh of routers. Every node raises a flag when its oldest frame buffer has drained. The block combines all flags and, once every node is empty in the same cycle, sends a one-cycle advance pulse back to every node. Each node then moves its head-frame pointer on by one.

The network is a tree built one dimension at a time. In each column, the node at the column's middle row collects the flags of that column, one register per hop. The middle-row node of the middle column then combines the column results, again one register per hop, and decides whether to advance. The advance command goes back over the same tree in reverse: first along the middle row, then down each column.

The shorter paths are padded with registers, so every flag reaches the root after the same number of cycles and every node receives the pulse in the same cycle. The full round trip is therefore fixed at 4·H cycles, where H = ceil((K-1)/2) is the hop count from an edge node to its center. After the root issues an advance, it ignores further results until fresh flags, sampled after the pulse, can have come back. One empty condition can therefore never cause two advances.

Top module: `mesh_barrier`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every bit of `node_advance` is 0.
- R2: A pulse is issued only when every one of the K·K bits of `node_empty` was 1 in one and the same cycle. A single 0 bit at any position (corner, edge or center) prevents the pulse.
- R3: When all bits of `node_empty` are 1 in the cycle sampled at clock edge e (and no lockout is active), `node_advance` is high right after edge e + 4·H, with H = ceil((K-1)/2). For K = 5 this is edge e + 8.
- R4: In every cycle, `node_advance` is either all zeros or all ones. Every node advances in the same cycle.
- R5: Each pulse on `node_advance` lasts exactly one cycle.
- R6: Flags from different cycles are never combined. If node A is the only non-empty node in one cycle and node B is the only non-empty node in the next, no pulse results.
- R7: After the root decides to advance at edge f, results reaching it at edges f+1 through f+4·H are ignored. If all nodes stay empty, the pulses therefore repeat every 4·H+1 cycles. An all-empty cycle whose result reaches the root at edge f+4·H+1 or later produces a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_empty | input | K*K | Head-frame-empty flag per node; bit r*K+c is row r, column c |
| node_advance | output | K*K | One-cycle advance pulse per node, same bit order |

## Verification
Any corruption in a gather chain or its padding shows up as a pulse missing from, or added to, the cycle exactly 4·H after an all-empty cycle. A pattern that is all-empty only when skewed across cycles exposes a misaligned pad within the same 4·H window. A wrong broadcast stage or pad splits the pulse across nodes, which is visible as a partly set output vector. A wrong lockout count moves the repeat period of a held all-empty condition away from 4·H+1, or lets an all-empty cycle that arrives during the window through, within two round trips.

// File: rtl/mb_pkg.sv
package mb_pkg;
  // Index of the middle position of a line of n nodes.
  function automatic int center_of(input int n);
    return (n - 1) / 2;
  endfunction

  // Largest hop count from any node of the line to its middle: ceil((n-1)/2).
  function automatic int reach_of(input int n);
    return n / 2;
  endfunction
endpackage

// File: rtl/mb_delay.sv
module mb_delay #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else begin
      sr[0] <= d;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  assign q = sr[DEPTH-1];
endmodule

// File: rtl/mb_gather_line.sv
// AND-reduces one line of flags toward its middle node, one register per hop.
// Near nodes are padded so that every flag arrives after exactly H cycles.
module mb_gather_line
  import mb_pkg::*;
#(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  output logic         all_set
);
  localparam int C = center_of(N);
  localparam int H = reach_of(N);

  logic [N-1:0] padded;
  logic [N-1:0] hop;

  for (genvar p = 0; p < N; p++) begin : g_node
    localparam int DIST = (p < C) ? (C - p) : (p - C);
    localparam int PAD  = H - DIST;

    if (PAD == 0) begin : g_nopad
      assign padded[p] = flags[p];
    end else begin : g_pad
      mb_delay #(.DEPTH(PAD)) u_pad (.clk(clk), .rst(rst), .d(flags[p]), .q(padded[p]));
    end

    if (p < C) begin : g_lo
      logic prev;
      logic acc_q;
      if (p == 0) begin : g_end
        assign prev = 1'b1;
      end else begin : g_mid
        assign prev = hop[p-1];
      end
      always_ff @(posedge clk) begin
        if (rst) acc_q <= 1'b0;
        else     acc_q <= prev & padded[p];
      end
      assign hop[p] = acc_q;
    end else if (p > C) begin : g_hi
      logic prev;
      logic acc_q;
      if (p == N - 1) begin : g_end
        assign prev = 1'b1;
      end else begin : g_mid
        assign prev = hop[p+1];
      end
      always_ff @(posedge clk) begin
        if (rst) acc_q <= 1'b0;
        else     acc_q <= prev & padded[p];
      end
      assign hop[p] = acc_q;
    end else begin : g_root
      logic lo_in;
      logic hi_in;
      if (p == 0) begin : g_nolo
        assign lo_in = 1'b1;
      end else begin : g_lo_in
        assign lo_in = hop[p-1];
      end
      if (p == N - 1) begin : g_nohi
        assign hi_in = 1'b1;
      end else begin : g_hi_in
        assign hi_in = hop[p+1];
      end
      assign hop[p]  = padded[p];
      assign all_set = hop[p] & lo_in & hi_in;
    end
  end
endmodule

// File: rtl/mb_bcast_line.sv
// Spreads a pulse from the middle node outward, one register per hop.
// Each output is padded so that all nodes see the pulse exactly H cycles later.
module mb_bcast_line
  import mb_pkg::*;
#(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d,
  output logic [N-1:0] q
);
  localparam int C = center_of(N);
  localparam int H = reach_of(N);

  logic [N-1:0] hop;

  for (genvar p = 0; p < N; p++) begin : g_node
    localparam int DIST = (p < C) ? (C - p) : (p - C);
    localparam int PAD  = H - DIST;

    if (p < C) begin : g_lo
      logic stg_q;
      always_ff @(posedge clk) begin
        if (rst) stg_q <= 1'b0;
        else     stg_q <= hop[p+1];
      end
      assign hop[p] = stg_q;
    end else if (p > C) begin : g_hi
      logic stg_q;
      always_ff @(posedge clk) begin
        if (rst) stg_q <= 1'b0;
        else     stg_q <= hop[p-1];
      end
      assign hop[p] = stg_q;
    end else begin : g_src
      assign hop[p] = d;
    end

    if (PAD == 0) begin : g_nopad
      assign q[p] = hop[p];
    end else begin : g_pad
      mb_delay #(.DEPTH(PAD)) u_pad (.clk(clk), .rst(rst), .d(hop[p]), .q(q[p]));
    end
  end
endmodule

// File: rtl/mesh_barrier.sv
module mesh_barrier
  import mb_pkg::*;
#(
  parameter int K = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [K*K-1:0] node_empty,
  output logic [K*K-1:0] node_advance
);
  localparam int H    = reach_of(K);
  localparam int LOCK = 4 * H;
  localparam int CW   = $clog2(LOCK + 1);

  logic [K-1:0] col_all;
  logic         root_all;
  logic         fire_q;
  logic [CW-1:0] hold_cnt;
  logic [K-1:0] col_go;

  // Stage 1: each column reduces toward its middle row.
  for (genvar c = 0; c < K; c++) begin : g_col_gather
    logic [K-1:0] cflags;
    for (genvar r = 0; r < K; r++) begin : g_row
      assign cflags[r] = node_empty[r*K + c];
    end
    mb_gather_line #(.N(K)) u_gather (
      .clk(clk), .rst(rst), .flags(cflags), .all_set(col_all[c])
    );
  end

  // Stage 2: the middle row reduces the column results at the root.
  mb_gather_line #(.N(K)) u_row_gather (
    .clk(clk), .rst(rst), .flags(col_all), .all_set(root_all)
  );

  // Root decision with lockout, so one empty condition yields one advance.
  always_ff @(posedge clk) begin
    if (rst) begin
      fire_q   <= 1'b0;
      hold_cnt <= '0;
    end else begin
      fire_q <= root_all && (hold_cnt == '0);
      if (root_all && (hold_cnt == '0)) hold_cnt <= CW'(LOCK);
      else if (hold_cnt != '0)          hold_cnt <= hold_cnt - 1'b1;
    end
  end

  // Reverse tree: along the middle row, then down every column.
  mb_bcast_line #(.N(K)) u_row_bcast (
    .clk(clk), .rst(rst), .d(fire_q), .q(col_go)
  );

  for (genvar c = 0; c < K; c++) begin : g_col_bcast
    logic [K-1:0] cpulse;
    mb_bcast_line #(.N(K)) u_bcast (
      .clk(clk), .rst(rst), .d(col_go[c]), .q(cpulse)
    );
    for (genvar r = 0; r < K; r++) begin : g_row
      assign node_advance[r*K + c] = cpulse[r];
    end
  end
endmodule

// File: rtl/mesh_barrier_chk.sv
module mesh_barrier_chk
  import mb_pkg::*;
#(
  parameter int K = 5
) (
  input logic           clk,
  input logic           rst,
  input logic [K*K-1:0] node_empty,
  input logic [K*K-1:0] node_advance
);
  localparam int H   = reach_of(K);
  localparam int LAT = 4 * H;
  localparam int GW  = $clog2(LAT + 1);

  logic [LAT:0]  hist;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      gap  <= GW'(LAT);
    end else begin
      hist <= {hist[LAT-1:0], &node_empty};
      if (|node_advance)         gap <= '0;
      else if (gap != GW'(LAT))  gap <= gap + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (node_advance == '0));

  assert_needs_all_empty_R2: assert property (@(posedge clk) disable iff (rst)
    (|node_advance) |-> hist[LAT]);

  assert_same_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    ((node_advance == '0) || (&node_advance)));

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    (|node_advance) |=> (node_advance == '0));

  assert_lockout_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (|node_advance) |-> (gap == GW'(LAT)));
endmodule

bind mesh_barrier mesh_barrier_chk #(.K(K)) u_chk (
  .clk(clk), .rst(rst), .node_empty(node_empty), .node_advance(node_advance)
);

// File: tb/mesh_barrier_test.sv
module mesh_barrier_test;
  localparam int K          = 5;
  localparam int N          = K * K;
  localparam int H          = K / 2;      // ceil((K-1)/2)
  localparam int LAT        = 4 * H;      // round trip, R3
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] node_empty;
  logic [N-1:0] node_advance;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mesh_barrier #(.K(K)) uut (
    .clk(clk), .rst(rst), .node_empty(node_empty), .node_advance(node_advance)
  );

  function automatic logic [N-1:0] pattern(input bit hit);
    return hit ? {N{1'b1}} : {N{1'b0}};
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: node_advance=%h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(req, node_advance, '0);
    end
  endtask

  // R1: reset holds outputs low even with all flags set.
  task automatic t_reset_R1();
    rst = 1'b1;
    node_empty = '1;
    quiet("R1", 3);
    rst = 1'b0;
    node_empty = '0;
    quiet("R1", LAT + 4);
  endtask

  // R3, R4, R5: one all-empty cycle gives one pulse on all nodes after LAT edges.
  task automatic t_one_shot_R3();
    @(negedge clk);
    node_empty = '1;
    for (int i = 0; i <= LAT + 6; i++) begin
      @(negedge clk);
      if (i == 0) node_empty = '0;
      check("R3 R4 R5", node_advance, pattern(i == LAT));
    end
  endtask

  // R2: one busy node anywhere blocks the advance.
  task automatic t_blocker_R2();
    int pos[4] = '{0, 12, 24, 7};
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      node_empty = '1;
      node_empty[pos[j]] = 1'b0;
      quiet("R2", LAT + 6);
      node_empty = '0;
      quiet("R2", LAT + 2);
    end
  endtask

  // R6: all-empty only when skewed across two cycles must not fire.
  task automatic t_skew_R6(input int a, input int b);
    @(negedge clk);
    node_empty = ~(N'(1) << a);
    @(negedge clk);
    check("R6", node_advance, '0);
    node_empty = ~(N'(1) << b);
    @(negedge clk);
    check("R6", node_advance, '0);
    node_empty = '0;
    quiet("R6", LAT + 4);
  endtask

  // R7: an all-empty cycle inside the lockout is dropped; one after it fires.
  task automatic t_lockout_R7();
    @(negedge clk);
    node_empty = '1;
    for (int i = 0; i <= 30; i++) begin
      @(negedge clk);
      node_empty = (i == 2 || i == 8) ? '1 : '0;
      check("R7", node_advance, pattern(i == LAT || i == LAT + 9));
    end
    quiet("R7", LAT);
  endtask

  // R7: held all-empty condition pulses every LAT+1 cycles.
  task automatic t_stream_R7();
    int last_empty = 38;
    @(negedge clk);
    node_empty = '1;
    for (int i = 0; i <= 60; i++) begin
      @(negedge clk);
      if (i == last_empty) node_empty = '0;
      check("R7", node_advance,
            pattern(i >= LAT && ((i - LAT) % (LAT + 1)) == 0 && (i - LAT) <= last_empty));
    end
  endtask

  initial begin
    t_reset_R1();
    t_one_shot_R3();
    t_blocker_R2();
    t_skew_R6(0, 12);
    t_skew_R6(12, 0);
    t_skew_R6(24, 20);
    t_lockout_R7();
    t_stream_R7();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements): still running, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule